// File: doc/BRIEF.md
# Prescaled Tick Timer with Overflow Interrupt

This block is an 8-bit up-counter. The system clock drives it through a prescaler, and a 3-bit select code chooses the divide ratio. A small register interface is decoded from a 2-bit word address, and it exposes four registers: the count, a control register holding the select code, an overflow flag and an interrupt mask. Reads are combinational. Writes take effect on the rising clock edge when `bus_wr` is high.

The prescaler is a free-running 10-bit divide counter. It starts at zero when reset is released and then increments on every clock. An enabled count happens on each edge where the low `k` bits of the divide counter are all ones, with `k = log2(ratio)`. When the counter wraps from 0xFF to 0x00 it sets the overflow flag. The block requests an interrupt while three things are set: the flag, the mask bit and the global enable input. The flag clears itself when the interrupt is acknowledged.

Top module: `tick_timer`

## Requirements
- R1: With select code 0 the counter holds its value on every clock, unless the count register is written.
- R2: Select codes 1, 2, 3, 4 and 5 give 1, 8, 64, 256 and 1024 clocks per count. Number the clock edges after reset release as e = 0, 1, 2, and so on. The counter increments on edge e when e mod ratio equals ratio-1.
- R3: Select codes 6 and 7 behave like code 0, and the counter does not count.
- R4: The register map has four word addresses:
  - Address 0 is the count register. All 8 bits read and write.
  - Address 1 is the control register. Bits [2:0] hold the select code and read back; bits [7:3] read as 0.
  - Address 2 is the flag register. Bit 0 is the overflow flag; the other bits read as 0.
  - Address 3 is the mask register. Bit 0 is the interrupt mask; the other bits read as 0.
- R5: When the counter is at 0xFF, the next enabled count makes it 0x00.
- R6: The wrap sets the overflow flag on the same edge that the counter becomes 0x00.
- R7: `irq_req` is 1 exactly when the flag, mask bit 0 and `gie` are all 1, evaluated combinationally.
- R8: If `irq_ack` is high while `irq_req` is high, the flag clears on that edge. An `irq_ack` while `irq_req` is low has no effect.
- R9: While the mask bit or `gie` is 0, a set flag stays set and `irq_req` stays 0.
- R10: A write to the count register takes priority over an enabled count in the same cycle. Such a cycle never produces a wrap, even when the counter was at 0xFF.
- R11: Writing a value with bit 0 = 1 to the flag register clears the flag. Writing a value with bit 0 = 0 leaves the flag unchanged.
- R12: If a wrap and a clear (a software write or an acknowledge) fall in the same cycle, the flag ends up 1.
- R13: After reset, the count, select code, flag and mask all read 0, and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Overflow interrupt request |

## Verification
Two kinds of collision can fall in the same cycle:
- A software write to the count register lands on an edge where the prescaler also issues a count while the counter sits at 0xFF. This pits the load against the increment and the wrap.
- A hardware flag set from a wrap lands on an edge that also carries a flag-clear write or an acknowledge.

Both are provoked by loading 0xFF at divide-by-1 and then issuing the competing write or acknowledge on the following edge. A behavioural model advances the counter, flag and prescaler phase on each edge using the priority rules. It is compared against every register and `irq_req` on every clock, so the winner of each collision is checked in the very cycle after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_FLAG  = 2'd2,
    REG_MASK  = 2'd3
  } reg_addr_e;

  // log2 of the divide ratio for each select code
  function automatic logic [3:0] sel_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd10;
      default: return 4'd0;
    endcase
  endfunction

  // codes 1..5 run; 0, 6 and 7 stop the counter
  function automatic logic sel_running(input logic [SEL_W-1:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] div_mask;
  logic [3:0]       shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_q + 1'b1;
  end

  always_comb begin
    shift    = sel_shift(sel);
    div_mask = ~({PSC_W{1'b1}} << shift);
    tick     = sel_running(sel) && ((psc_q & div_mask) == div_mask);
  end

  // R2: with a ratio of 8 or more, two counts are never back to back
  assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel >= 3'd2 && sel <= 3'd5) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = step && !load && (cnt_q == {CNT_W{1'b1}});
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assert_load_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic sw_clr_i,
  input  logic ack_i,
  input  logic mask_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic taken;

  assign irq_o  = flag_q & mask_i & gie_i;
  assign taken  = ack_i & irq_o;
  assign flag_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (set_i)              flag_q <= 1'b1;
    else if (sw_clr_i || taken)  flag_q <= 1'b0;
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i && !set_i) |=> !flag_o);

  assert_sw_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !set_i) |=> !flag_o);

  assert_flag_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(mask_i && gie_i) && !sw_clr_i) |=> flag_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PSC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gie,
  input  logic              irq_ack,
  output logic              irq_req
);
  localparam int CNT_W = DATA_W;

  logic [SEL_W-1:0] sel_q;
  logic             mask_q;
  logic             tick;
  logic             cnt_load;
  logic             flag_clr;
  logic             wrap;
  logic             flag;
  logic [CNT_W-1:0] cnt;

  assign cnt_load = bus_wr && (bus_addr == REG_COUNT);
  assign flag_clr = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == REG_CTRL) sel_q  <= bus_wdata[SEL_W-1:0];
      if (bus_addr == REG_MASK) mask_q <= bus_wdata[0];
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(bus_wdata),
    .step(tick), .cnt(cnt), .wrap(wrap)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(wrap), .sw_clr_i(flag_clr),
    .ack_i(irq_ack), .mask_i(mask_q), .gie_i(gie),
    .flag_o(flag), .irq_o(irq_req)
  );

  always_comb begin
    case (bus_addr)
      REG_COUNT: bus_rdata = cnt;
      REG_CTRL:  bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      REG_FLAG:  bus_rdata = {{(DATA_W-1){1'b0}}, flag};
      default:   bus_rdata = {{(DATA_W-1){1'b0}}, mask_q};
    endcase
  end

  assert_hold_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0 && !cnt_load) |=> $stable(cnt));

  assert_hold_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q >= 3'd6 && !cnt_load) |=> $stable(cnt));

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && cnt == {CNT_W{1'b1}}) |=> flag);
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_req;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int m_cnt = 0, m_sel = 0, m_flag = 0, m_mask = 0;
  bit g_cur = 1'b0;

  always #2 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h (edge %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int ratio(input int s);
    case (s)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic int model_reg(input int a);
    case (a)
      0: return m_cnt;
      1: return m_sel;
      2: return m_flag;
      default: return m_mask;
    endcase
  endfunction

  // Starts at a falling edge, ends at the next falling edge.
  task automatic step(input bit wr, input int addr, input int wd, input bit g,
                      input bit ack, input string tag);
    int r, n_cnt, n_flag, n_sel, n_mask;
    bit tk, ld, set_w, clr, irq_m;
    bus_wr = 1'b0;
    irq_ack = 1'b0;
    for (int a = 0; a < 4; a++) begin
      bus_addr = a[1:0];
      #0.1;
      chk(tag, $sformatf("reg%0d", a), int'(bus_rdata), model_reg(a));
    end
    bus_wr = wr; bus_addr = addr[1:0]; bus_wdata = wd[7:0]; gie = g; irq_ack = ack;
    #0.1;
    irq_m = (m_flag != 0) && (m_mask != 0) && g;
    chk(tag, "irq_req", int'(irq_req), int'(irq_m));
    r      = ratio(m_sel);
    tk     = (r != 0) && ((cyc % r) == r - 1);
    ld     = wr && addr == 0;
    set_w  = tk && !ld && m_cnt == 255;
    n_cnt  = ld ? (wd & 255) : (tk ? ((m_cnt + 1) % 256) : m_cnt);
    clr    = (wr && addr == 2 && (wd & 1) != 0) || (ack && irq_m);
    n_flag = set_w ? 1 : (clr ? 0 : m_flag);
    n_sel  = (wr && addr == 1) ? (wd & 7) : m_sel;
    n_mask = (wr && addr == 3) ? (wd & 1) : m_mask;
    @(posedge clk);
    m_cnt = n_cnt; m_flag = n_flag; m_sel = n_sel; m_mask = n_mask;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, g_cur, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, 0, 1'b0, 1'b0, "R13");
    // stopped counter holds a written value
    step(1'b1, 0, 'h10, 1'b0, 1'b0, "R1");
    run(50, "R1");
    // every divide ratio
    step(1'b1, 1, 1, 1'b0, 1'b0, "R2"); run(20, "R2");
    step(1'b1, 1, 2, 1'b0, 1'b0, "R2"); run(40, "R2");
    step(1'b1, 1, 3, 1'b0, 1'b0, "R2"); run(200, "R2");
    step(1'b1, 1, 4, 1'b0, 1'b0, "R2"); run(600, "R2");
    step(1'b1, 1, 5, 1'b0, 1'b0, "R2"); run(2100, "R2");
    // external codes stop
    step(1'b1, 1, 6, 1'b0, 1'b0, "R3"); run(100, "R3");
    step(1'b1, 1, 7, 1'b0, 1'b0, "R3"); run(100, "R3");
    // register map, unused bits read zero
    step(1'b1, 1, 'hFD, 1'b0, 1'b0, "R4"); run(3, "R4");
    step(1'b1, 3, 'hFE, 1'b0, 1'b0, "R4");
    step(1'b1, 1, 0, 1'b0, 1'b0, "R4");
    // wrap and flag set
    step(1'b1, 0, 'hFD, 1'b0, 1'b0, "R5");
    step(1'b1, 1, 1, 1'b0, 1'b0, "R5");
    run(5, "R6");
    g_cur = 1'b1; run(3, "R9");
    step(1'b1, 3, 1, 1'b0, 1'b0, "R9");
    g_cur = 1'b0; run(3, "R9");
    g_cur = 1'b1; run(3, "R7");
    step(1'b0, 0, 0, 1'b0, 1'b1, "R8");
    step(1'b0, 0, 0, 1'b1, 1'b1, "R8");
    run(2, "R8");
    // software clear
    step(1'b1, 0, 'hFF, 1'b1, 1'b0, "R11");
    run(2, "R11");
    step(1'b1, 1, 0, 1'b1, 1'b0, "R11");
    step(1'b1, 2, 'hFE, 1'b1, 1'b0, "R11"); run(1, "R11");
    step(1'b1, 2, 1, 1'b1, 1'b0, "R11"); run(1, "R11");
    // load versus count at 0xFF
    step(1'b1, 3, 0, 1'b1, 1'b0, "R10");
    step(1'b1, 1, 1, 1'b1, 1'b0, "R10");
    step(1'b1, 0, 'hFF, 1'b1, 1'b0, "R10");
    step(1'b1, 0, 'h33, 1'b1, 1'b0, "R10");
    run(3, "R10");
    // set versus software clear
    step(1'b1, 0, 'hFF, 1'b1, 1'b0, "R12");
    step(1'b1, 2, 1, 1'b1, 1'b0, "R12");
    run(1, "R12");
    step(1'b1, 2, 1, 1'b1, 1'b0, "R11");
    // set versus acknowledge
    step(1'b1, 3, 1, 1'b1, 1'b0, "R12");
    step(1'b1, 0, 'hFF, 1'b1, 1'b0, "R12");
    run(1, "R12");
    step(1'b1, 0, 'hFF, 1'b1, 1'b0, "R12");
    step(1'b0, 0, 0, 1'b1, 1'b1, "R12");
    run(2, "R12");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule